// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the 64-byte type-0 configuration header of one PCI function and answers configuration reads and writes of one, two or four bytes at a byte offset. Identity fields (vendor, device, class and revision, header type, subsystem, interrupt pin) come from parameters and never change. The command, status, cache line size, latency timer and interrupt line fields, the six base address registers and the expansion ROM register can be written, each under its own width rules. Header state is loaded from parameters at reset.

Each base address register runs the usual sizing exchange. A probe of all ones makes it read back the inverted size mask, and its read-only type bits are kept. Once a write leaves a nonzero base in a BAR, that BAR drives a hit output for a downstream address that falls inside its window. A later write moves the window to the new base.

Requests use a two-state handshake. In state `CH_IDLE` the block raises `req_ready`. A request seen while ready takes the transition *accept* to state `CH_RESP`. In `CH_RESP` the block holds `rsp_valid` high for one cycle, then takes the transition *complete* back to `CH_IDLE`. With no request, `CH_IDLE` stays where it is.

Top module: `cfg_header_regs`

## Requirements
- R1: A request with `req_valid` high while `req_ready` is high is accepted. On the next cycle `rsp_valid` is high and `req_ready` is low. One cycle after that, `req_ready` is high again and `rsp_valid` is low. The response to a write carries zero read data.
- R2: After reset the header reads as follows. Vendor ID is at 0x00 and device ID at 0x02. Command is at 0x04 and status at 0x06. The 32-bit class/revision word is at 0x08. Cache line size is at 0x0C, latency timer at 0x0D and header type at 0x0E. BAR i is at 0x10+4·i. The subsystem word is at 0x2C and the expansion ROM register at 0x30. Interrupt line is at 0x3C and interrupt pin at 0x3D. Every other byte reads zero, and all values come from parameters.
- R3: `req_size` selects the access width: 0 is one byte, 1 is two bytes, 2 is four bytes. A read returns the bytes at offset, offset+1, … in little-endian order in `rsp_rdata`, and the unused upper bits are zero. Any offset alignment is allowed.
- R4: A request with `req_size`=3, or one whose bytes would reach offset 0x40 or beyond, gets `rsp_err` high and zero data, and changes no state.
- R5: A one-byte write changes only the byte at 0x0C, 0x0D or 0x3C, taking `req_wdata[7:0]`. One-byte writes anywhere else are ignored.
- R6: A two-byte write changes only command (0x04), status (0x06), or the pair at 0x0C/0x0D, taking `req_wdata[15:0]`. Two-byte writes anywhere else are ignored.
- R7: A four-byte write at 0x04 stores `req_wdata[15:0]` into the command field and leaves status unchanged.
- R8: Four-byte writes at offsets other than 0x04, the BAR words and 0x30 are ignored. The identity fields ignore writes of every width.
- R9: A four-byte write of 0xFFFFFFFF to BAR i makes it read ~(size_i−1) OR its read-only low bits. Bit 0 set marks I/O space, with bits 1:0 read-only. Bit 0 clear marks memory space, with bits 3:0 read-only.
- R10: Any other four-byte BAR write stores the written value, keeping the read-only low bits from the current contents.
- R11: A BAR's decode window is enabled only after a write whose value, with bit 0 cleared (I/O) or bits 1:0 cleared (memory), is nonzero. That masked value becomes the base. `bar_hit[i]` is high when the BAR is enabled and base ≤ `dec_addr` < base+size_i.
- R12: A later such write moves the window to the new base. A write whose masked value is zero leaves the window as it was.
- R13: A four-byte write of 0xFFFFFFFE at 0x30 makes it read 0xFFFFFFFF. Any other value is stored exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code |
| req_offset | input | 8 | Byte offset into the header |
| req_wdata | input | 32 | Write data, least significant byte first |
| req_ready | output | 1 | Block is in CH_IDLE and accepts a request |
| rsp_valid | output | 1 | Response present (CH_RESP) |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Request was rejected |
| dec_addr | input | 32 | Downstream address to decode |
| bar_hit | output | 6 | Per-BAR window hit |

## Verification
The bound checker checks the handshake on every cycle: each accepted request gets exactly one response cycle, write responses carry zero data, and an invalid width code is always flagged. It also checks that the hit vector can change only when the decode address moves or a write has just been accepted. The width filtering, the sizing read-back, the expansion ROM probe value, window placement and window moves depend on stored contents, so only the bench's scenarios show them. The bench does this through full read sweeps after write sweeps of every width at every offset, and through edge-address probes around each window.

// File: rtl/cfghdr_pkg.sv
package cfghdr_pkg;
    localparam int DATA_W    = 32;
    localparam int OFS_W     = 8;
    localparam int NUM_BAR   = 6;
    localparam int HDR_BYTES = 64;
    localparam int HDR_WORDS = HDR_BYTES / 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RESP = 1'b1
    } ch_state_e;

    localparam logic [OFS_W-1:0] OFS_CMD   = 8'h04;
    localparam logic [OFS_W-1:0] OFS_STAT  = 8'h06;
    localparam logic [OFS_W-1:0] OFS_CACHE = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_LAT   = 8'h0D;
    localparam logic [OFS_W-1:0] OFS_BAR0  = 8'h10;
    localparam logic [OFS_W-1:0] OFS_ROM   = 8'h30;
    localparam logic [OFS_W-1:0] OFS_INTL  = 8'h3C;

    localparam int WORD_BAR0 = 4;
    localparam int WORD_SUBS = 11;
    localparam int WORD_ROM  = 12;
    localparam int WORD_INT  = 15;

    function automatic logic [2:0] width_bytes(input logic [1:0] code);
        case (code)
            SZ_BYTE: width_bytes = 3'd1;
            SZ_HALF: width_bytes = 3'd2;
            SZ_WORD: width_bytes = 3'd4;
            default: width_bytes = 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
    import cfghdr_pkg::*;
#(
    parameter logic [DATA_W-1:0] INIT = '0,
    parameter logic [DATA_W-1:0] SIZE = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dec_addr,
    output logic [DATA_W-1:0] reg_q,
    output logic              hit
);
    // type bit 0 never changes, so the read-only mask is fixed per slot
    localparam logic [DATA_W-1:0] RO_MASK  = INIT[0] ? 32'h0000_0003 : 32'h0000_000F;
    localparam logic [DATA_W-1:0] BASE_KEEP = INIT[0] ? 32'hFFFF_FFFE : 32'hFFFF_FFFC;
    localparam logic [DATA_W-1:0] SIZE_INV  = ~(SIZE - 32'd1);

    logic [DATA_W-1:0] base_q;
    logic              en_q;
    logic [DATA_W-1:0] new_base;
    logic [DATA_W:0]   lim;

    assign new_base = wdata & BASE_KEEP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q  <= INIT;
            base_q <= '0;
            en_q   <= 1'b0;
        end else if (we) begin
            if (wdata == '1) begin
                reg_q <= SIZE_INV | (reg_q & RO_MASK);
            end else begin
                reg_q <= (wdata & ~RO_MASK) | (reg_q & RO_MASK);
                if (new_base != '0) begin
                    base_q <= new_base;
                    en_q   <= 1'b1;
                end
            end
        end
    end

    assign lim = {1'b0, base_q} + {1'b0, SIZE};
    assign hit = en_q && (dec_addr >= base_q) && ({1'b0, dec_addr} < lim);
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfghdr_pkg::*;
(
    input  logic [HDR_WORDS-1:0][DATA_W-1:0] words,
    input  logic [5:0]                       offset,
    input  logic [2:0]                       nbytes,
    output logic [DATA_W-1:0]                rdata
);
    logic [HDR_BYTES-1:0][7:0] hdr_bytes;
    logic [6:0]                idx;

    assign hdr_bytes = words;

    always_comb begin
        rdata = '0;
        idx   = '0;
        for (int i = 0; i < 4; i++) begin
            idx = {1'b0, offset} + 7'(i);
            if ((3'(i) < nbytes) && (idx < 7'(HDR_BYTES)))
                rdata[8*i +: 8] = hdr_bytes[idx[5:0]];
        end
    end
endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
    import cfghdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID     = 16'h0B1E,
    parameter logic [31:0] CLASS_REV     = 32'h0280_0003,
    parameter logic [7:0]  HEADER_TYPE   = 8'h00,
    parameter logic [31:0] SUBSYS_IDS    = 32'h5A5A_1234,
    parameter logic [7:0]  INT_PIN       = 8'h01,
    parameter logic [15:0] CMD_INIT      = 16'h0000,
    parameter logic [15:0] STAT_INIT     = 16'h0290,
    parameter logic [7:0]  CACHE_INIT    = 8'h00,
    parameter logic [7:0]  LAT_INIT      = 8'h00,
    parameter logic [7:0]  INTL_INIT     = 8'h00,
    parameter logic [31:0] ROM_INIT      = 32'h0000_0000,
    parameter logic [NUM_BAR-1:0][31:0] BAR_INIT = {32'h0, 32'h0, 32'h1, 32'h8, 32'h1, 32'h0},
    parameter logic [NUM_BAR-1:0][31:0] BAR_SIZE = {32'h40, 32'h1_0000, 32'h4, 32'h10, 32'h100, 32'h1000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    input  logic [DATA_W-1:0] dec_addr,
    output logic [NUM_BAR-1:0] bar_hit
);
    ch_state_e state_q, state_d;

    logic              accept;
    logic [2:0]        nbytes;
    logic              bad_req;
    logic              wr_ok;
    logic [15:0]       cmd_q, stat_q;
    logic [7:0]        cache_q, lat_q, intl_q;
    logic [31:0]       rom_q;
    logic [NUM_BAR-1:0]             bar_we;
    logic [NUM_BAR-1:0][DATA_W-1:0] bar_q;
    logic [HDR_WORDS-1:0][DATA_W-1:0] hdr_w;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;

    // ---------------- request decode ----------------
    assign accept  = (state_q == CH_IDLE) && req_valid;
    assign nbytes  = width_bytes(req_size);
    assign bad_req = (req_size == SZ_BAD) ||
                     (({1'b0, req_offset} + 9'(nbytes)) > 9'(HDR_BYTES));
    assign wr_ok   = accept && req_write && !bad_req;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (req_valid) state_d = CH_RESP;
            CH_RESP: state_d = CH_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready = (state_q == CH_IDLE);
        rsp_valid = (state_q == CH_RESP);
        rsp_rdata = rsp_valid ? rdata_q : '0;
        rsp_err   = rsp_valid && err_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (accept) begin
            err_q   <= bad_req;
            rdata_q <= (bad_req || req_write) ? '0 : rd_mux;
        end
    end

    // ---------------- writable scalar fields ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= CMD_INIT;
            stat_q  <= STAT_INIT;
            cache_q <= CACHE_INIT;
            lat_q   <= LAT_INIT;
            intl_q  <= INTL_INIT;
            rom_q   <= ROM_INIT;
        end else if (wr_ok) begin
            unique case (req_size)
                SZ_BYTE: begin
                    if (req_offset == OFS_CACHE) cache_q <= req_wdata[7:0];
                    if (req_offset == OFS_LAT)   lat_q   <= req_wdata[7:0];
                    if (req_offset == OFS_INTL)  intl_q  <= req_wdata[7:0];
                end
                SZ_HALF: begin
                    if (req_offset == OFS_CMD)  cmd_q  <= req_wdata[15:0];
                    if (req_offset == OFS_STAT) stat_q <= req_wdata[15:0];
                    if (req_offset == OFS_CACHE) begin
                        cache_q <= req_wdata[7:0];
                        lat_q   <= req_wdata[15:8];
                    end
                end
                SZ_WORD: begin
                    if (req_offset == OFS_CMD) cmd_q <= req_wdata[15:0];
                    if (req_offset == OFS_ROM)
                        rom_q <= (req_wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : req_wdata;
                end
                default: ;
            endcase
        end
    end

    // ---------------- base address registers ----------------
    for (genvar g = 0; g < NUM_BAR; g++) begin : g_bar
        assign bar_we[g] = wr_ok && (req_size == SZ_WORD) &&
                           (req_offset == OFS_BAR0 + OFS_W'(4 * g));
        cfg_bar_slot #(
            .INIT (BAR_INIT[g]),
            .SIZE (BAR_SIZE[g])
        ) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (bar_we[g]),
            .wdata    (req_wdata),
            .dec_addr (dec_addr),
            .reg_q    (bar_q[g]),
            .hit      (bar_hit[g])
        );
    end

    // ---------------- header image and read path ----------------
    always_comb begin
        hdr_w    = '0;
        hdr_w[0] = {DEVICE_ID, VENDOR_ID};
        hdr_w[1] = {stat_q, cmd_q};
        hdr_w[2] = CLASS_REV;
        hdr_w[3] = {8'h00, HEADER_TYPE, lat_q, cache_q};
        for (int i = 0; i < NUM_BAR; i++) hdr_w[WORD_BAR0 + i] = bar_q[i];
        hdr_w[WORD_SUBS] = SUBSYS_IDS;
        hdr_w[WORD_ROM]  = rom_q;
        hdr_w[WORD_INT]  = {16'h0000, INT_PIN, intl_q};
    end

    cfg_read_mux i_rmux (
        .words  (hdr_w),
        .offset (req_offset[5:0]),
        .nbytes (nbytes),
        .rdata  (rd_mux)
    );
endmodule

// File: rtl/cfg_header_chk.sv
module cfg_header_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [1:0]  req_size,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [31:0] rsp_rdata,
    input logic [31:0] dec_addr,
    input logic [5:0]  bar_hit
);
    // R1
    accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid && !req_ready));

    // R1
    resp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));

    // R1
    wr_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> (rsp_rdata == 32'h0));

    // R4
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_size == 2'b11) |=> rsp_err);

    // R11
    hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(dec_addr) && !$past(req_valid && req_ready && req_write)) |-> $stable(bar_hit));
endmodule

bind cfg_header_regs cfg_header_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .dec_addr  (dec_addr),
    .bar_hit   (bar_hit)
);

// File: tb/test_cfg_header_regs.sv
module test_cfg_header_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [7:0]  req_offset = 8'd0;
    logic [31:0] req_wdata = 32'd0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [31:0] dec_addr = 32'd0;
    logic [5:0]  bar_hit;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0]  mdl [64];
    logic [31:0] m_base [6];
    bit          m_en [6];
    logic [31:0] m_size [6];
    logic [31:0] m_init [6];

    always #2.5 clk = ~clk;

    cfg_header_regs #(
        .VENDOR_ID(16'hC0DE), .DEVICE_ID(16'h0B1E), .CLASS_REV(32'h0280_0003),
        .HEADER_TYPE(8'h00), .SUBSYS_IDS(32'h5A5A_1234), .INT_PIN(8'h01),
        .CMD_INIT(16'h0000), .STAT_INIT(16'h0290), .CACHE_INIT(8'h00),
        .LAT_INIT(8'h00), .INTL_INIT(8'h00), .ROM_INIT(32'h0),
        .BAR_INIT({32'h0, 32'h0, 32'h1, 32'h8, 32'h1, 32'h0}),
        .BAR_SIZE({32'h40, 32'h1_0000, 32'h4, 32'h10, 32'h100, 32'h1000})
    ) i_cfg_header_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_offset(req_offset), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .dec_addr(dec_addr), .bar_hit(bar_hit)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic void put32(input int o, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mdl[o + k] = v[8*k +: 8];
    endfunction

    function automatic logic [31:0] get32(input int o);
        logic [31:0] v;
        for (int k = 0; k < 4; k++) v[8*k +: 8] = mdl[o + k];
        return v;
    endfunction

    function automatic void mdl_reset();
        for (int k = 0; k < 64; k++) mdl[k] = 8'h00;
        put32(8'h00, 32'h0B1E_C0DE);
        put32(8'h04, 32'h0290_0000);
        put32(8'h08, 32'h0280_0003);
        put32(8'h0C, 32'h0000_0000);
        put32(8'h2C, 32'h5A5A_1234);
        put32(8'h3C, 32'h0000_0100);
        m_init = '{32'h0, 32'h1, 32'h8, 32'h1, 32'h0, 32'h0};
        m_size = '{32'h1000, 32'h100, 32'h10, 32'h4, 32'h1_0000, 32'h40};
        for (int b = 0; b < 6; b++) begin
            put32(16 + 4*b, m_init[b]);
            m_base[b] = 0;
            m_en[b]   = 0;
        end
    endfunction

    function automatic void mdl_write(input int sz, input int o, input logic [31:0] d);
        logic [31:0] ro, keep, cur;
        int b;
        if (sz == 0) begin
            if (o == 12 || o == 13 || o == 60) mdl[o] = d[7:0];
        end else if (sz == 1) begin
            if (o == 4 || o == 6 || o == 12) begin
                mdl[o] = d[7:0];
                mdl[o + 1] = d[15:8];
            end
        end else if (sz == 2) begin
            if (o == 4) begin
                mdl[4] = d[7:0];
                mdl[5] = d[15:8];
            end else if (o == 48) begin
                put32(48, (d == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : d);
            end else if (o >= 16 && o <= 36 && (o % 4) == 0) begin
                b    = (o - 16) / 4;
                ro   = m_init[b][0] ? 32'h3 : 32'hF;
                keep = m_init[b][0] ? 32'hFFFF_FFFE : 32'hFFFF_FFFC;
                cur  = get32(o);
                if (d == 32'hFFFF_FFFF) put32(o, ~(m_size[b] - 1) | (cur & ro));
                else begin
                    put32(o, (d & ~ro) | (cur & ro));
                    if ((d & keep) != 0) begin
                        m_base[b] = d & keep;
                        m_en[b]   = 1;
                    end
                end
            end
        end
    endfunction

    function automatic logic [31:0] mdl_read(input int sz, input int o);
        logic [31:0] v = 0;
        int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        for (int k = 0; k < n; k++) v[8*k +: 8] = mdl[o + k];
        return v;
    endfunction

    function automatic logic [5:0] mdl_hit(input logic [31:0] a);
        logic [5:0] h = 0;
        for (int b = 0; b < 6; b++)
            h[b] = m_en[b] && (a >= m_base[b]) &&
                   ({1'b0, a} < ({1'b0, m_base[b]} + {1'b0, m_size[b]}));
        return h;
    endfunction

    // one request; response sampled at the next falling edge
    task automatic access(input bit wr, input int sz, input int o, input logic [31:0] d,
                          output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_size   = 2'(sz);
        req_offset = 8'(o);
        req_wdata  = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd1);
        chk("R1 ready low", 32'(req_ready), 32'd0);
        rd = rsp_rdata;
        er = rsp_err;
        if (wr) chk("R1 write data", rd, 32'h0);
    endtask

    task automatic wr_chk(input string req, input int sz, input int o, input logic [31:0] d);
        logic [31:0] rd;
        logic er;
        bit oob = (o + ((sz == 0) ? 1 : (sz == 1) ? 2 : 4)) > 64 || sz == 3;
        access(1, sz, o, d, rd, er);
        chk(req, 32'(er), 32'(oob));
        if (!oob) mdl_write(sz, o, d);
    endtask

    task automatic read_sweep(input string req);
        logic [31:0] rd;
        logic er;
        for (int o = 0; o < 64; o++) begin
            for (int sz = 0; sz < 3; sz++) begin
                int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
                access(0, sz, o, 0, rd, er);
                if (o + n > 64) begin
                    chk("R4 err", 32'(er), 32'd1);
                    chk("R4 data", rd, 32'h0);
                end else begin
                    chk("R3 no err", 32'(er), 32'd0);
                    chk(req, rd, mdl_read(sz, o));
                end
            end
        end
    endtask

    task automatic hit_probe(input string req, input logic [31:0] a);
        @(negedge clk);
        dec_addr = a;
        #1;
        chk(req, 32'(bar_hit), 32'(mdl_hit(a)));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mdl_reset();
    endtask

    initial begin
        logic [31:0] rd;
        logic er;
        mdl_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ready", 32'(req_ready), 32'd1);
        chk("R1 reset idle", 32'(rsp_valid), 32'd0);
        chk("R11 reset no hit", 32'(bar_hit), 32'd0);

        read_sweep("R2 reset image");
        @(negedge clk);
        chk("R1 back to idle", 32'(req_ready), 32'd1);
        chk("R1 single response", 32'(rsp_valid), 32'd0);

        // R5: byte writes everywhere
        for (int o = 0; o < 64; o++) wr_chk("R5 byte write", 0, o, 32'h0000_00A5 ^ 32'(o));
        read_sweep("R5 after byte sweep");
        // R6: half writes everywhere
        for (int o = 0; o < 63; o++) wr_chk("R6 half write", 1, o, 32'h0000_5A00 | 32'(o));
        read_sweep("R6 after half sweep");
        // R8, R7, R10, R13: word writes everywhere
        for (int o = 0; o < 61; o++) wr_chk("R8 word write", 2, o, 32'hA000_0030 + (32'(o) << 8));
        read_sweep("R8 after word sweep");

        // R4: rejected requests leave state alone
        wr_chk("R4 word oob", 2, 61, 32'h1111_1111);
        wr_chk("R4 half oob", 1, 63, 32'h2222_2222);
        wr_chk("R4 byte oob", 0, 64, 32'h33);
        wr_chk("R4 bad size", 3, 12, 32'h44);
        access(0, 3, 0, 0, rd, er);
        chk("R4 bad size read", 32'(er), 32'd1);
        read_sweep("R4 state unchanged");

        // R7: word write at command keeps status
        wr_chk("R7 word cmd", 2, 4, 32'hDEAD_BEEF);
        access(0, 2, 4, 0, rd, er);
        chk("R7 cmd only", rd, {mdl_read(1, 6)[15:0], 16'hBEEF});

        // R9: sizing probes
        for (int b = 0; b < 6; b++) begin
            wr_chk("R9 probe", 2, 16 + 4*b, 32'hFFFF_FFFF);
            access(0, 2, 16 + 4*b, 0, rd, er);
            chk("R9 size mask", rd, ~(m_size[b] - 1) | (m_init[b] & (m_init[b][0] ? 32'h3 : 32'hF)));
        end

        // R13: expansion ROM
        wr_chk("R13 write", 2, 48, 32'hFFFF_FFFE);
        access(0, 2, 48, 0, rd, er);
        chk("R13 probe reads all ones", rd, 32'hFFFF_FFFF);
        wr_chk("R13 write", 2, 48, 32'h1234_5001);
        access(0, 2, 48, 0, rd, er);
        chk("R13 stored", rd, 32'h1234_5001);

        // R11/R12: decode windows from a clean reset
        do_reset();
        hit_probe("R11 disabled", 32'h0);
        wr_chk("R12 zero base", 2, 32, 32'h0);
        hit_probe("R11 zero base no enable", 32'h0);
        wr_chk("R11 prog", 2, 16, 32'h4000_0000);
        wr_chk("R11 prog", 2, 20, 32'h0000_C001);
        wr_chk("R11 prog", 2, 24, 32'h5000_0008);
        wr_chk("R11 prog", 2, 28, 32'h0000_D005);
        wr_chk("R11 prog", 2, 32, 32'h6001_0000);
        wr_chk("R11 prog", 2, 36, 32'h7000_0040);
        for (int b = 0; b < 6; b++) begin
            hit_probe("R11 below", m_base[b] - 1);
            hit_probe("R11 base", m_base[b]);
            hit_probe("R11 top", m_base[b] + m_size[b] - 1);
            hit_probe("R11 past", m_base[b] + m_size[b]);
        end
        wr_chk("R12 move", 2, 16, 32'h4800_0000);
        hit_probe("R12 old base", 32'h4000_0000);
        hit_probe("R12 new base", 32'h4800_0000);
        wr_chk("R12 zero write", 2, 16, 32'h0000_0000);
        hit_probe("R12 kept after zero", 32'h4800_0FFF);
        wr_chk("R12 io zero base", 2, 20, 32'h0000_0001);
        hit_probe("R12 io kept", 32'h0000_C0FF);
        access(0, 2, 20, 0, rd, er);
        chk("R10 io low bits", rd, 32'h0000_0001);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule